// File: doc/BRIEF.md
# Switching Clock Source Selector with Sync Detection

This block produces the start-of-cycle strobe for a switching regulator's power stage. Normally a free-running internal counter sets both the rate and the phase of the switching cycle. An active-low external sync pin is watched by a rate monitor. Once that pin shows a steady train of falling edges, close enough together, the block hands cycle timing to the sync pin, and every sync falling edge starts a switching cycle a fixed, short latency later. When the edges stop or slow down, timing goes back to the internal counter without emitting a short cycle.

All timing is counted in system-clock cycles. With a 100 MHz system clock, an internal period of 100 counts gives a 1 MHz switching rate. A detect limit of 333 counts corresponds to a threshold near 300 kHz. This covers the usable external range of 600 kHz to 1.4 MHz with margin. The block has no mode pin: the measured edge rate alone chooses the source. An enable input suppresses strobes without stopping the rate monitor.

Top module: `swclk_select`

## Requirements
- R1: During and right after a synchronous reset, `cyc_start` and `ext_sync` are both 0.
- R2: With `ext_sync` at 0 and `en` high, `cyc_start` pulses exactly every INT_PERIOD (100) clock cycles. This holds whether the sync pin sits high or low.
- R3: After `en` rises, the first internal pulse appears after exactly INT_PERIOD rising edges, counting the first edge that sees `en` high as edge 1.
- R4: While `en` is low, `cyc_start` stays 0 in both internal and external mode.
- R5: `ext_sync` rises at the third sync falling edge whose two preceding intervals are both at most DET_LIMIT (333) cycles. After only two such edges it is still 0.
- R6: A falling-edge interval of DET_LIMIT+1 (334) cycles or more breaks the run. A sync train of period 334 never sets `ext_sync`, while a period of 333 does.
- R7: In external mode, each sync falling edge produces one `cyc_start` pulse on the third rising clock edge after the pin falls. No other pulses occur within that sync period.
- R8: With `ext_sync` at 1 and no further sync falling edge, `ext_sync` is still 1 after edge DET_LIMIT+2 following the last pin fall and is 0 after edge DET_LIMIT+3.
- R9: After `ext_sync` clears, the internal counter restarts from zero. The first internal pulse comes INT_PERIOD+1 edges after the clear is seen, never sooner.
- R10: `cyc_start` is never high for two consecutive cycles.
- R11: The rate monitor and `ext_sync` keep working while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables cycle-start strobes |
| sync_n | input | 1 | Raw active-low external sync pin, asynchronous |
| cyc_start | output | 1 | One-cycle switching-cycle start strobe |
| ext_sync | output | 1 | High while the external sync pin sets cycle timing |

## Verification
The assertions assume that the sync pin stays high for at least one full clock cycle between falls, so two detected falls are never adjacent. They also assume that `en` is a synchronous signal. The bench changes `sync_n` and `en` only at falling clock edges and holds the pin high for half of every sync period. Sync periods are chosen from 150 to 400 cycles, well above the synchronizer depth. This keeps every latency measured in whole edges, so the exact-count checks on lock, timeout and restart are deterministic.

// File: rtl/swclk_pkg.sv
package swclk_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } swclk_src_e;
endpackage

// File: rtl/swclk_sync_fall.sv
module swclk_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] shr;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shr    <= '1;
      last_q <= 1'b1;
    end else begin
      shr[0] <= pin_n;
      for (int i = 1; i < STAGES; i++) shr[i] <= shr[i-1];
      last_q <= shr[STAGES-1];
    end
  end

  assign fall = last_q & ~shr[STAGES-1];

  AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R10
endmodule

// File: rtl/swclk_rate_det.sv
module swclk_rate_det
  import swclk_pkg::*;
#(
  parameter int LIMIT = 333,
  parameter int NEED  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fall,
  output swclk_src_e src
);
  localparam int GW = $clog2(LIMIT + 1);
  localparam int SW = $clog2(NEED + 1);
  localparam logic [GW-1:0] LIM    = GW'(LIMIT);
  localparam logic [GW-1:0] LIM_M1 = GW'(LIMIT - 1);
  localparam logic [SW-1:0] STK_MAX = SW'(NEED);
  localparam logic [SW-1:0] STK_ARM = SW'(NEED - 1);

  logic [GW-1:0] gap_q;
  logic [SW-1:0] streak_q;
  swclk_src_e    src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q    <= LIM;
      streak_q <= '0;
      src_q    <= SRC_INT;
    end else if (fall) begin
      gap_q <= '0;
      if (gap_q < LIM) begin
        if (streak_q >= STK_ARM) src_q <= SRC_EXT;
        if (streak_q < STK_MAX) streak_q <= streak_q + 1'b1;
      end else begin
        streak_q <= '0;
      end
    end else if (gap_q == LIM_M1) begin
      gap_q    <= LIM;
      streak_q <= '0;
      src_q    <= SRC_INT;
    end else if (gap_q < LIM) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign src = src_q;

  AST_EXT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(src_q) |-> $past(fall)); // R5
  AST_DROP_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(src_q) |-> !$past(fall)); // R8
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap_q <= LIM); // R6
endmodule

// File: rtl/swclk_int_timer.sv
module swclk_int_timer #(
  parameter int PERIOD = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/swclk_select.sv
module swclk_select
  import swclk_pkg::*;
#(
  parameter int INT_PERIOD     = 100,
  parameter int DET_LIMIT      = 333,
  parameter int LOCK_INTERVALS = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sync_n,
  output logic cyc_start,
  output logic ext_sync
);
  logic       fall;
  logic       tick;
  logic       mode_chg;
  swclk_src_e src;
  swclk_src_e src_prev_q;
  logic       cs_q;

  swclk_sync_fall #(.STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst(rst), .pin_n(sync_n), .fall(fall)
  );

  swclk_rate_det #(.LIMIT(DET_LIMIT), .NEED(LOCK_INTERVALS)) u_det (
    .clk(clk), .rst(rst), .fall(fall), .src(src)
  );

  assign mode_chg = (src != src_prev_q);

  swclk_int_timer #(.PERIOD(INT_PERIOD)) u_tmr (
    .clk(clk), .rst(rst), .clr(!en || mode_chg), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev_q <= SRC_INT;
      cs_q       <= 1'b0;
    end else begin
      src_prev_q <= src;
      if (src == SRC_EXT) cs_q <= en & fall;
      else                cs_q <= en & tick & ~mode_chg;
    end
  end

  assign cyc_start = cs_q;
  assign ext_sync  = (src == SRC_EXT);

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> $past(en)); // R4
  AST_EXT_PULSE_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cs_q && $past(src == SRC_EXT)) |-> $past(fall)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !cs_q); // R10
endmodule

// File: tb/tb_swclk_select.sv
module tb_swclk_select;
  localparam int P   = 100;
  localparam int LIM = 333;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic sync_n = 1'b1;
  logic cyc_start;
  logic ext_sync;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  swclk_select dut (
    .clk(clk), .rst(rst), .en(en), .sync_n(sync_n),
    .cyc_start(cyc_start), .ext_sync(ext_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b1; sync_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cyc_start == 0 && ext_sync == 0, "R1 in reset", {cyc_start, ext_sync}, 0);
    rst = 1'b0;
  endtask

  // one sync period of T cycles starting with a fall; reports latency of first pulse
  task automatic sync_period(input int T, output int lat, output int npulse);
    lat = 0; npulse = 0;
    sync_n = 1'b0;
    for (int i = 1; i <= T; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == T / 2) sync_n = 1'b1;
      if (cyc_start) begin
        npulse++;
        if (lat == 0) lat = i;
      end
    end
  endtask

  task automatic edges_to_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!cyc_start && n < 2000);
  endtask

  task automatic t_reset_internal();
    int n;
    do_reset();
    @(negedge clk);
    chk(cyc_start == 0 && ext_sync == 0, "R1 after release", {cyc_start, ext_sync}, 0);
    edges_to_pulse(n);
    @(posedge clk); @(negedge clk);
    chk(cyc_start == 0, "R10 width", cyc_start, 0);
    edges_to_pulse(n);
    chk(n == P - 1, "R2 interval sync high", n + 1, P);
    edges_to_pulse(n);
    chk(n == P, "R2 interval sync high again", n, P);
    chk(ext_sync == 0, "R2 stays internal", ext_sync, 0);
  endtask

  task automatic t_enable();
    int n, cnt;
    do_reset();
    @(negedge clk); en = 1'b0; cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      if (cyc_start) cnt++;
    end
    chk(cnt == 0, "R4 no pulses with en low", cnt, 0);
    en = 1'b1;
    edges_to_pulse(n);
    chk(n == P, "R3 first pulse after enable", n, P);
  endtask

  task automatic t_lock_and_drop();
    int lat, np, n;
    bit ok_hi;
    do_reset();
    sync_period(150, lat, np);
    sync_period(150, lat, np);
    chk(ext_sync == 0, "R5 not after two edges", ext_sync, 0);
    sync_period(150, lat, np);
    chk(ext_sync == 1, "R5 set at third edge", ext_sync, 1);
    for (int k = 0; k < 3; k++) begin
      sync_period(150, lat, np);
      chk(lat == 3, "R7 edge to pulse latency", lat, 3);
      chk(np == 1, "R7 one pulse per period", np, 1);
    end
    // final fall, then silence
    sync_n = 1'b0; n = 0; ok_hi = 1'b0;
    for (int i = 1; i <= LIM + 3; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 75) sync_n = 1'b1;
      if (i == LIM + 2) ok_hi = ext_sync;
    end
    chk(ok_hi == 1, "R8 held before timeout", ok_hi, 1);
    chk(ext_sync == 0, "R8 dropped at timeout", ext_sync, 0);
    edges_to_pulse(n);
    chk(n == P + 1, "R9 restart after drop", n, P + 1);
    edges_to_pulse(n);
    chk(n == P, "R2 interval after drop", n, P);
  endtask

  task automatic t_boundary(input int T, input bit exp_ext, input string req);
    int lat, np;
    do_reset();
    for (int k = 0; k < 5; k++) sync_period(T, lat, np);
    chk(ext_sync == exp_ext, req, ext_sync, exp_ext);
  endtask

  task automatic t_static_low();
    int n;
    do_reset();
    @(negedge clk); sync_n = 1'b0;
    edges_to_pulse(n);
    edges_to_pulse(n);
    chk(n == P, "R2 interval sync low", n, P);
    repeat (400) @(negedge clk);
    chk(ext_sync == 0, "R2 static low stays internal", ext_sync, 0);
  endtask

  task automatic t_ext_disabled();
    int lat, np, tot;
    do_reset();
    @(negedge clk); en = 1'b0; tot = 0;
    for (int k = 0; k < 6; k++) begin
      sync_period(150, lat, np);
      tot += np;
    end
    chk(ext_sync == 1, "R11 locks with en low", ext_sync, 1);
    chk(tot == 0, "R4 no pulses in ext mode with en low", tot, 0);
    en = 1'b1;
    sync_period(150, lat, np);
    chk(lat == 3 && np == 1, "R7 pulse resumes after enable", lat, 3);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_internal();
    t_enable();
    t_lock_and_drop();
    t_boundary(333, 1'b1, "R6 period at limit locks");
    t_boundary(334, 1'b0, "R6 period above limit stays internal");
    t_boundary(400, 1'b0, "R6 slow sync stays internal");
    t_static_low();
    t_ext_disabled();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule